// File: doc/BRIEF.md
# SPI Byte Transceiver with Master and Slave Roles

This block moves one byte at a time over a four-wire serial link and can take either end of it. A static role input picks the side. As the clocking side it makes the serial clock from the system clock with a programmable half-period. As the clocked side it oversamples the incoming clock, select and data lines. A single 8-bit shift register serves both roles. Bits go out most significant first in mode 0: the input is sampled on the rising serial clock edge and the output changes on the falling edge.

The host side is a set of strobes. A write strobe loads the byte to send, and in master role it starts the transfer at once. The received byte sits in a holding register. A read strobe and a separate clear strobe acknowledge it. A completion flag and an interrupt line report the end of each byte, and a collision flag reports a write made while a byte is still moving. In master role the block never drives a select line on its own. The host drives a separate select output, which the block only registers.

Top module: `spi_byte_ctrl`

## Requirements
- R1: After reset, done_flag, wcol_flag, irq, sck_o and miso_oe are 0, rd_data is 8'h00 and cs_n_o is 1.
- R2: In master role (mode_master=1), a wr_en pulse while idle starts a transfer. mosi_o presents wr_data MSB first and changes only on falling sck_o edges. miso_i is sampled on each rising sck_o edge, and the 8 sampled bits, first bit in bit 7, appear on rd_data at the end.
- R3: In master role sck_o idles low and gives exactly 8 pulses with a period of 2*div system clocks. A div of 0 acts as 1.
- R4: At the end of a byte done_flag goes to 1 and sck_o stays low. done_flag holds until an rd_en or flag_clr pulse clears it on the next clock.
- R5: irq is 1 exactly when done_flag is 1 and irq_en is 1.
- R6: A wr_en pulse during an active transfer leaves the outgoing bits unchanged and sets wcol_flag, which holds until a flag_clr pulse.
- R7: In slave role (mode_master=0), miso_oe is 0 while ss_n_i is high and 1 while it is low. sck_i edges while ss_n_i is high shift nothing and set no flag, and a byte written then is the one sent next.
- R8: In slave role with ss_n_i low and every sck_i phase longer than 2 system clocks, mosi_i is sampled on rising sck_i edges into rd_data. miso_o gives the loaded byte MSB first. done_flag rises on the third system clock after the 8th falling sck_i edge.
- R9: In slave role, ss_n_i rising before the 8th bit abandons the byte: done_flag stays 0 and the next full transfer is received and sent correctly.
- R10: If a completed byte is not read before the next one completes, rd_data holds the newer byte and the older one is lost.
- R11: cs_n_o is the inverse of cs_assert one clock later, whatever the transfer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = master role, 0 = slave role |
| div | input | DIV_W | Master SCK half-period in system clocks (0 acts as 1) |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe, clears done_flag |
| flag_clr | input | 1 | Clear strobe for done_flag and wcol_flag |
| rd_data | output | 8 | Receive holding register |
| done_flag | output | 1 | Byte transfer complete |
| wcol_flag | output | 1 | Write collision during a transfer |
| irq | output | 1 | Interrupt request |
| cs_assert | input | 1 | Host request to assert the master select line |
| cs_n_o | output | 1 | Registered active-low select output |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock in |
| ss_n_i | input | 1 | Slave select in, active low |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Slave data output enable (1 = drive) |

## Verification
A bit counter that drifts shows up at once as a ninth or a seventh sck_o pulse, or as a done_flag that comes a whole bit period early or late. A shift register that takes a write while busy corrupts the very next mosi_o bit. A broken holding register shows a wrong rd_data as soon as done_flag rises. In slave role, an extra synchronizer stage or a missed edge moves the done_flag rise away from the third clock after the last falling edge. A reset that does not follow select leaves the byte after an abandoned one shifted by the stale bit count.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  // Effective half period of the master clock in system clocks.
  function automatic int unsigned half_period(int unsigned div);
    return (div == 0) ? 1 : div;
  endfunction

  // Shift one bit in at the LSB end, MSB leaves first.
  function automatic byte_t shift_in(byte_t cur, logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_byte_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick      = run && (cnt == DIV_W'(half_period(32'(div)) - 1));
  assign tick_rise = tick & ~sck;
  assign tick_fall = tick & sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck); // R3
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_byte_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_master,
  input  logic  load,
  input  byte_t load_data,
  input  logic  rise,
  input  logic  fall,
  input  logic  abort,
  input  logic  in_bit,
  output logic  out_bit,
  output logic  run,
  output logic  busy,
  output logic  byte_done,
  output byte_t rx_byte
);
  byte_t            sreg;
  logic [CNT_W-1:0] cnt;
  logic             hi;
  logic             samp;
  logic             last_bit;

  assign last_bit  = (cnt == CNT_W'(BYTE_W - 1));
  assign byte_done = fall && last_bit && !abort;
  assign busy      = run | hi | (cnt != '0);
  assign out_bit   = sreg[BYTE_W-1];
  assign rx_byte   = shift_in(sreg, samp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
      hi   <= 1'b0;
      samp <= 1'b0;
      run  <= 1'b0;
    end else begin
      if (load) begin
        sreg <= load_data;
        if (mode_master) run <= 1'b1;
      end
      if (abort) begin
        cnt <= '0;
        hi  <= 1'b0;
      end else if (rise) begin
        samp <= in_bit;
        hi   <= 1'b1;
      end else if (fall) begin
        sreg <= shift_in(sreg, samp);
        hi   <= 1'b0;
        cnt  <= cnt + 1'b1;
        if (last_bit) run <= 1'b0;
      end
    end
  end

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fall |=> $stable(sreg)); // R6
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_master,
  input  logic [DIV_W-1:0] div,
  input  logic             irq_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  input  logic             flag_clr,
  output logic [7:0]       rd_data,
  output logic             done_flag,
  output logic             wcol_flag,
  output logic             irq,
  input  logic             cs_assert,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  input  logic             sck_i,
  input  logic             ss_n_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe
);
  // Slave inputs: {sck, ss_n, mosi}, select resets inactive.
  logic [2:0] s_in;
  logic       s_sck, s_ss_n, s_mosi, s_sck_q;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, ss_n_i, mosi_i}), .q(s_in)
  );
  assign {s_sck, s_ss_n, s_mosi} = s_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_sck_q <= 1'b0;
    else        s_sck_q <= s_sck;
  end

  // Named internal events.
  logic s_sel, s_rise, s_fall, abort;
  logic m_rise, m_fall, run, busy, byte_done, load, out_bit;
  logic rise, fall, in_bit;
  byte_t rx_byte;

  assign s_sel  = !mode_master && !s_ss_n;
  assign s_rise = s_sel && s_sck && !s_sck_q;
  assign s_fall = s_sel && !s_sck && s_sck_q;
  assign abort  = !mode_master && s_ss_n;
  assign load   = wr_en && !busy;

  spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div),
    .sck(sck_o), .tick_rise(m_rise), .tick_fall(m_fall)
  );

  assign rise   = mode_master ? m_rise : s_rise;
  assign fall   = mode_master ? m_fall : s_fall;
  assign in_bit = mode_master ? miso_i : s_mosi;

  spi_shift_core u_core (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
    .load(load), .load_data(wr_data), .rise(rise), .fall(fall),
    .abort(abort), .in_bit(in_bit), .out_bit(out_bit), .run(run),
    .busy(busy), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  assign mosi_o  = out_bit;
  assign miso_o  = out_bit;
  assign miso_oe = s_sel;
  assign irq     = done_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
      cs_n_o    <= 1'b1;
    end else begin
      cs_n_o <= ~cs_assert;
      if (byte_done) begin
        rd_data   <= rx_byte;
        done_flag <= 1'b1;
      end else if (rd_en || flag_clr) begin
        done_flag <= 1'b0;
      end
      if (wr_en && busy)  wcol_flag <= 1'b1;
      else if (flag_clr)  wcol_flag <= 1'b0;
    end
  end

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done_flag); // R4
  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rd_data == $past(rx_byte)); // R10
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> wcol_flag); // R6
  AST_MISO_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !mode_master); // R7
endmodule

// File: tb/tb_spi_byte_ctrl.sv
module tb_spi_byte_ctrl;
  logic clk = 0, rst_n = 0;
  logic mode_master = 1, irq_en = 0, wr_en = 0, rd_en = 0, flag_clr = 0;
  logic cs_assert = 0, miso_i = 0, sck_i = 0, ss_n_i = 1, mosi_i = 0;
  logic [3:0] div = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic done_flag, wcol_flag, irq, cs_n_o, sck_o, mosi_o, miso_o, miso_oe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_byte_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .div(div),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .flag_clr(flag_clr), .rd_data(rd_data), .done_flag(done_flag),
    .wcol_flag(wcol_flag), .irq(irq), .cs_assert(cs_assert), .cs_n_o(cs_n_o),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
    .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    wr_data = b; wr_en = 1; @(negedge clk); wr_en = 0; @(negedge clk);
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sv,
                             input int d, input bit collide);
    logic [7:0] cap = 0;
    int rises = 0, falls = 0, cyc = 0, last = -1, bad = 0;
    int eff = (d == 0) ? 1 : d;
    bit prev = 0, wrote = 0;
    div = 4'(d); miso_i = sv[7];
    @(negedge clk);
    wr_data = tx; wr_en = 1; @(negedge clk); wr_en = 0;
    while (!done_flag && cyc < 40 * eff + 40) begin
      wr_en = 0;
      if (sck_o && !prev) begin
        cap = {cap[6:0], mosi_o};
        if (last >= 0 && cyc - last != 2 * eff) bad++;
        last = cyc; rises++;
      end
      if (!sck_o && prev) begin
        falls++;
        if (falls < 8) miso_i = sv[7-falls];
      end
      if (collide && rises == 3 && !wrote) begin
        wr_data = ~tx; wr_en = 1; wrote = 1;
      end
      prev = sck_o;
      @(negedge clk); cyc++;
    end
    wr_en = 0;
    chk("R2 mosi byte", cap, tx);
    chk("R2 rd_data", rd_data, sv);
    chk("R3 pulse count", rises, 8);
    chk("R3 period errors", bad, 0);
    chk("R4 done", done_flag, 1);
    repeat (3) @(negedge clk);
    chk("R4 sck stopped", sck_o, 0);
    chk("R4 done held", done_flag, 1);
    if (collide) chk("R6 wcol", wcol_flag, 1);
  endtask

  task automatic slave_xfer(input logic [7:0] mv, input int p, input int nbits,
                            input bit pre_chk, output logic [7:0] cap);
    cap = 0;
    ss_n_i = 0; repeat (4) @(negedge clk);
    chk("R7 oe low select", miso_oe, 1);
    for (int b = 0; b < nbits; b++) begin
      mosi_i = mv[7-b];
      repeat (p) @(negedge clk);
      cap = {cap[6:0], miso_o};
      sck_i = 1;
      repeat (p) @(negedge clk);
      sck_i = 0;
    end
    if (nbits == 8) begin
      repeat (2) @(negedge clk);
      if (pre_chk) chk("R8 done not early", done_flag, 0);
      @(negedge clk);
      chk("R8 done on third clock", done_flag, 1);
    end
    repeat (2) @(negedge clk);
    ss_n_i = 1; repeat (4) @(negedge clk);
    chk("R7 oe high select", miso_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] cap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", done_flag, 0); chk("R1 wcol", wcol_flag, 0);
    chk("R1 irq", irq, 0); chk("R1 sck", sck_o, 0);
    chk("R1 oe", miso_oe, 0); chk("R1 rd_data", rd_data, 0);
    chk("R1 cs", cs_n_o, 1);
    rst_n = 1; @(negedge clk);

    // R11 select output
    cs_assert = 1; @(negedge clk);
    chk("R11 cs asserted", cs_n_o, 0);

    // R2/R3 all bytes at div 1
    for (int v = 0; v < 256; v++) begin
      master_xfer(8'(v), 8'(v * 13 + 7), 1, 0);
      pulse_clr();
    end
    chk("R11 cs held through transfers", cs_n_o, 0);
    cs_assert = 0; @(negedge clk);
    chk("R11 cs released", cs_n_o, 1);

    // R3 divider sweep, div 0 acts as 1
    for (int d = 0; d < 6; d++) begin
      master_xfer(8'hA5 ^ 8'(d), 8'h3C + 8'(d), d, 0);
      pulse_clr();
    end

    // R5 interrupt
    irq_en = 1; @(negedge clk);
    chk("R5 irq idle", irq, 0);
    master_xfer(8'h81, 8'h7E, 2, 0);
    chk("R5 irq with flag", irq, 1);
    irq_en = 0; @(negedge clk);
    chk("R5 irq masked", irq, 0);
    irq_en = 1; @(negedge clk);
    pulse_clr();
    chk("R5 irq after clear", irq, 0);
    chk("R4 clr strobe", done_flag, 0);
    irq_en = 0;

    // R6 collision
    master_xfer(8'hC3, 8'h5A, 2, 1);
    pulse_clr();
    chk("R6 wcol cleared", wcol_flag, 0);

    // Slave role
    mode_master = 0; repeat (3) @(negedge clk);
    chk("R7 oe idle", miso_oe, 0);

    // R7 sck ignored while deselected
    wr(8'h5A);
    mosi_i = 1;
    for (int i = 0; i < 8; i++) begin
      sck_i = 1; repeat (3) @(negedge clk);
      sck_i = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R7 no flag deselected", done_flag, 0);
    chk("R7 oe deselected", miso_oe, 0);
    slave_xfer(8'h96, 3, 8, 1, cap);
    chk("R7 tx unchanged", cap, 8'h5A);
    chk("R8 rx", rd_data, 8'h96);
    pulse_clr();

    // R8 sweep all bytes at 3-clock phases
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      slave_xfer(8'(v) ^ 8'h96, 3, 8, 1, cap);
      chk("R8 miso byte", cap, v);
      chk("R8 rx byte", rd_data, v ^ 8'h96);
      pulse_clr();
    end
    for (int p = 4; p < 7; p++) begin
      wr(8'h1F + 8'(p));
      slave_xfer(8'hE4 - 8'(p), p, 8, 1, cap);
      chk("R8 miso slow", cap, 8'h1F + p);
      chk("R8 rx slow", rd_data, 8'hE4 - p);
      pulse_clr();
    end

    // R9 abandoned byte
    wr(8'hF0);
    slave_xfer(8'h00, 3, 3, 0, cap);
    chk("R9 no flag", done_flag, 0);
    wr(8'h6D);
    slave_xfer(8'hB9, 3, 8, 1, cap);
    chk("R9 miso after abort", cap, 8'h6D);
    chk("R9 rx after abort", rd_data, 8'hB9);
    pulse_clr();

    // R10 overwrite
    wr(8'h11);
    slave_xfer(8'hA1, 3, 8, 1, cap);
    chk("R10 first", rd_data, 8'hA1);
    wr(8'h22);
    slave_xfer(8'hB2, 4, 8, 0, cap);
    chk("R10 overwritten", rd_data, 8'hB2);
    chk("R10 flag held", done_flag, 1);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R4 read clears", done_flag, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule